// File: doc/BRIEF.md
# Parallel Word-Wide CRC Engine

This block keeps a running cyclic redundancy check over a message that arrives one data word per clock. Each cycle in which the valid strobe is high, the whole word is folded into a CRC state register in a single step. The step is an XOR network. It is derived when the design is elaborated, by repeating the one-bit Galois shift once for every data bit.

The generator polynomial, the state width, the starting value, the bit ordering and the final complement are all parameters. With the defaults the engine produces the common Ethernet-style CRC-32. Changing the polynomial to 0x1EDC6F41 gives the Castagnoli CRC-32C. The data word may be 8 or 64 bits wide. In a multi-byte word, byte lane 0 holds the earliest byte of the message.

A synchronous reset starts a new message. After the last word of a message, the result can be read from the output one clock later, and it stays there until the next valid word or reset.

Top module: `crc_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the state is loaded with `INIT`. From the next cycle `crc_out` shows `INIT` (complemented when `INVERT` is set), which is 0x00000000 with the defaults.
- R2: On a clock edge where `data_valid` is low and `rst` is low, the state keeps its value, and `crc_out` keeps its value in the next cycle.
- R3: `crc_out` is registered. A word driven together with `data_valid` does not change `crc_out` before the next rising edge. The updated value appears right after that edge.
- R4: With the defaults (polynomial 0x04C11DB7, `INIT` all ones, reflected, inverted), the ASCII bytes "123456789" fed one per cycle give 0xCBF43926. The single byte "1" gives 0x83DCEFB7.
- R5: With polynomial 0x1EDC6F41 and the other defaults, "123456789" fed one byte per cycle gives 0xE3069283.
- R6: With a 64-bit data word, byte lane k (bits 8k+7:8k) is the k-th byte of the word in message order. A 1024-byte message fed eight bytes per cycle gives the same CRC as the same message fed one byte per cycle.
- R7: With reflection selected, each byte is absorbed least significant bit first. For any message, the result equals a bit-serial reflected CRC that starts from all ones and complements its final value. This holds even when idle cycles are placed between words.
- R8: `crc_out` carries no unknown bits in any cycle after reset has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; reloads the initial state |
| data_in | input | DATA_W | Message word; lane 0 is the earliest byte |
| data_valid | input | 1 | High when `data_in` should be absorbed this cycle |
| crc_out | output | STATE_W | Registered CRC of all words absorbed since reset |

## Verification
Four properties are checked on every cycle: the output value after reset, that the output holds on cycles without a valid word, that the output never changes without a preceding valid word or reset, and that the output has no unknown bits. Only the bench scenarios can show that the XOR network computes the correct CRC. These scenarios are the standard check strings for both polynomials, and random messages, some with gaps between words, compared against a bit-serial model. They also show that the 64-bit lane order gives the same result as byte-at-a-time feeding over a long message.

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int STATE_W = 32,
  parameter logic [STATE_W-1:0] POLY = 32'h04C11DB7,
  parameter logic [STATE_W-1:0] INIT = '1,
  parameter bit REFLECT = 1'b1,
  parameter bit INVERT = 1'b1,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  data_in,
  input  logic               data_valid,
  output logic [STATE_W-1:0] crc_out
);

  localparam int IN_W = STATE_W + DATA_W;
  localparam logic [STATE_W-1:0] OUT_MASK = {STATE_W{INVERT}};

  typedef logic [STATE_W-1:0][IN_W-1:0] matrix_t;

  function automatic logic [STATE_W-1:0] mirror_poly();
    logic [STATE_W-1:0] r;
    for (int i = 0; i < STATE_W; i++) r[i] = POLY[STATE_W-1-i];
    return r;
  endfunction

  // Position in data_in of the k-th bit absorbed: lanes in order, LSB or MSB first in a lane
  function automatic int feed_index(int k);
    if (REFLECT) return k;
    return (k / 8) * 8 + 7 - (k % 8);
  endfunction

  // Symbolic unroll: row i lists which {data, state} inputs XOR into next state bit i
  function automatic matrix_t build_matrix();
    matrix_t m;
    logic [IN_W-1:0] fb;
    logic [STATE_W-1:0] rp;
    rp = mirror_poly();
    for (int i = 0; i < STATE_W; i++) begin
      m[i] = '0;
      m[i][i] = 1'b1;
    end
    for (int k = 0; k < DATA_W; k++) begin
      if (REFLECT) begin
        fb = m[0];
        fb[STATE_W + feed_index(k)] = ~fb[STATE_W + feed_index(k)];
        for (int i = 0; i < STATE_W - 1; i++) m[i] = m[i+1];
        m[STATE_W-1] = '0;
        for (int i = 0; i < STATE_W; i++) if (rp[i]) m[i] = m[i] ^ fb;
      end else begin
        fb = m[STATE_W-1];
        fb[STATE_W + feed_index(k)] = ~fb[STATE_W + feed_index(k)];
        for (int i = STATE_W - 1; i > 0; i--) m[i] = m[i-1];
        m[0] = '0;
        for (int i = 0; i < STATE_W; i++) if (POLY[i]) m[i] = m[i] ^ fb;
      end
    end
    return m;
  endfunction

  localparam matrix_t STEP = build_matrix();

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic [IN_W-1:0]    step_in;

  assign step_in = {data_in, state_q};

  for (genvar i = 0; i < STATE_W; i++) begin : g_row
    assign state_d[i] = ^(STEP[i] & step_in);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= INIT;
    else if (data_valid) state_q <= state_d;
  end

  assign crc_out = state_q ^ OUT_MASK;

  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> crc_out == (INIT ^ OUT_MASK));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !data_valid |=> $stable(crc_out));

  // R3: any change of the output traces back to a valid word or a reset one edge earlier
  assert_change_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (crc_out != $past(crc_out)) |-> ($past(data_valid) || $past(rst)));

  assert_known_R8: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(crc_out));

endmodule

// File: tb/tb_crc_engine.sv
module tb_crc_engine;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  d8 = '0;
  logic        v8 = 1'b0;
  logic [63:0] d64 = '0;
  logic        v64 = 1'b0;
  logic [31:0] crc_a, crc_c, crc_w;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [7:0] msg [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_engine #(.DATA_W(8)) dut (
    .clk(clk), .rst(rst), .data_in(d8), .data_valid(v8), .crc_out(crc_a));
  crc_engine #(.POLY(32'h1EDC6F41), .DATA_W(8)) dut_c (
    .clk(clk), .rst(rst), .data_in(d8), .data_valid(v8), .crc_out(crc_c));
  crc_engine #(.DATA_W(64)) dut_w (
    .clk(clk), .rst(rst), .data_in(d64), .data_valid(v64), .crc_out(crc_w));

  function automatic logic [31:0] ref_crc(input logic [31:0] rpoly, input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ msg[i][b];
        c = c >> 1;
        if (fb) c = c ^ rpoly;
      end
    return ~c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic feed_bytes(int len, bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk) v8 = 1'b0;
      end
      @(negedge clk);
      d8 = msg[i];
      v8 = 1'b1;
    end
    @(negedge clk) v8 = 1'b0;
  endtask

  task automatic feed_words(int len, bit gaps);
    for (int w = 0; w < len / 8; w++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk) v64 = 1'b0;
      end
      @(negedge clk);
      for (int j = 0; j < 8; j++) d64[j*8 +: 8] = msg[w*8 + j];
      v64 = 1'b1;
    end
    @(negedge clk) v64 = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 crc32 reset", crc_a, 32'h0);
    check("R1 crc32c reset", crc_c, 32'h0);
    check("R1 wide reset", crc_w, 32'h0);

    // R3: output unchanged until the edge, updated right after it
    msg[0] = 8'h31;
    @(negedge clk);
    d8 = 8'h31;
    v8 = 1'b1;
    #1 check("R3 before edge", crc_a, 32'h0);
    @(negedge clk) v8 = 1'b0;
    check("R3 after edge", crc_a, 32'h83DCEFB7);
    check("R4 single byte", crc_a, 32'h83DCEFB7);

    do_reset();
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    feed_bytes(9, 1'b0);
    check("R4 crc32 check string", crc_a, 32'hCBF43926);
    check("R5 crc32c check string", crc_c, 32'hE3069283);

    repeat (3) @(negedge clk);
    check("R2 idle hold crc32", crc_a, 32'hCBF43926);
    check("R2 idle hold crc32c", crc_c, 32'hE3069283);

    do_reset();
    check("R1 reset after message", crc_a, 32'h0);

    for (int i = 0; i < 1024; i++) msg[i] = 8'(i);
    feed_bytes(1024, 1'b0);
    feed_words(1024, 1'b0);
    check("R6 wide vs byte", crc_w, crc_a);
    check("R7 byte stream vs model", crc_a, ref_crc(32'hEDB88320, 1024));
    check("R6 wide vs model", crc_w, ref_crc(32'hEDB88320, 1024));
    check("R5 crc32c long vs model", crc_c, ref_crc(32'h82F63B78, 1024));

    for (int t = 0; t < 8; t++) begin
      int len = 8 * (1 + ($urandom % 24));
      for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
      do_reset();
      feed_bytes(len, 1'b1);
      feed_words(len, 1'b1);
      check("R7 random crc32", crc_a, ref_crc(32'hEDB88320, len));
      check("R5 random crc32c", crc_c, ref_crc(32'h82F63B78, len));
      check("R6 random wide", crc_w, ref_crc(32'hEDB88320, len));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule